// File: doc/BRIEF.md
# Per-Lane Write Leveling Controller

This sequencer aligns the outgoing data strobe of every byte lane to the clock as each memory device sees it. When started, it puts the devices into leveling mode with a write to mode register 1. It then walks a shared fine delay code upward from zero, one step at a time. At each step it waits a settle time and fires a burst of strobe pulses. It also samples the one-bit feedback each lane returns, which is the device's sample of the strobe taken on the clock's rising edge and sent back on data bit 0 of that lane.

Each lane resolves its feedback by majority vote. The lane records the first step where the vote goes from 0 to 1, which is where the strobe crosses the clock edge. It adds a quarter-clock offset to that step, saturates the sum to the delay field, and holds the result. A lane that never shows the edge is flagged as failed and keeps code 0. After the last step the controller writes mode register 1 again with the leveling bit cleared, and then raises done. The analog delay lines and the devices sit outside this block.

Top module: `wrlvl_ctrl`

## Requirements
- R1: On `start` from idle or finished, the next cycle issues a one-cycle `mr_wr` with `mr_reg` = 1 and `mr_val` equal to `mr1_base` with bit 7 forced to 1. This happens before any strobe pulse.
- R2: After the last step there is exactly one more `mr_wr` to register 1, with `mr_val` equal to `mr1_base` with bit 7 forced to 0. It occurs in the cycle just before `done` rises. `done` then stays high until the next `start`.
- R3: Lane l's code is bits [l*DW +: DW] of `dly`, where DW = log2(STEPS). Steps run 0 to STEPS-1 in ascending order. The trained code is the first step whose vote is 1 while the previous step's vote was 0, plus STEPS/2. The step before step 0 counts as a vote of 1. While a sweep runs, every lane shows the current step.
- R4: When the trained step plus STEPS/2 exceeds 2^DW-1, the lane's code saturates at 2^DW-1.
- R5: A lane with no 0-to-1 vote change anywhere in the sweep ends with `lane_fail[l]` = 1 and code 0. This covers feedback that is all zeros, all ones, or falls only.
- R6: Each step takes VOTES samples of `lvl_fb`, one in the cycle after each strobe pulse. The step's vote is 1 only when more than VOTES/2 of those samples are 1, so a single flipped sample changes nothing.
- R7: Every `strb_pulse` is preceded by at least `settle_cycles` full cycles in which `dly` has not changed.
- R8: After reset, `dly` is 0, `lane_fail` is 0, `done` is 0, and neither `mr_wr` nor `strb_pulse` is asserted. The two outputs are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a leveling run (taken when idle or finished) |
| settle_cycles | input | 8 | Wait after each delay change before pulsing |
| mr1_base | input | MRW | Base value of mode register 1 |
| mr_wr | output | 1 | Mode-register write strobe |
| mr_reg | output | 3 | Mode register number (always 1) |
| mr_val | output | MRW | Mode-register write value |
| strb_pulse | output | 1 | Request one data-strobe pulse on all lanes |
| lvl_fb | input | LANES | Per-lane leveling feedback (data bit 0) |
| dly | output | LANES*DW | Per-lane fine delay codes |
| lane_fail | output | LANES | Per-lane no-edge-found flag |
| done | output | 1 | Run finished, results valid |

## Verification
The device model returns feedback as a per-lane function of the lane's own delay code. Plain rising thresholds test edge search and offset, with thresholds near the top of the range testing saturation. A high-low-high window shows that the initial high run is not mistaken for an edge. All-zero and all-one lanes show that the fail flag covers both missing-edge shapes. A one-sample flip just below and exactly at an edge tells the majority vote apart from single sampling. Two runs with different settle times and mode-register bases separate the settle wait, and the forced setting and clearing of bit 7, from the rest of the register value.

// File: rtl/wrlvl_ctrl.sv
module wrlvl_ctrl #(
  parameter int LANES = 8,
  parameter int STEPS = 64,
  parameter int VOTES = 3,
  parameter int MRW   = 13
)(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [7:0]                        settle_cycles,
  input  logic [MRW-1:0]                    mr1_base,
  output logic                              mr_wr,
  output logic [2:0]                        mr_reg,
  output logic [MRW-1:0]                    mr_val,
  output logic                              strb_pulse,
  input  logic [LANES-1:0]                  lvl_fb,
  output logic [LANES*$clog2(STEPS)-1:0]    dly,
  output logic [LANES-1:0]                  lane_fail,
  output logic                              done
);
  localparam int DW  = $clog2(STEPS);
  localparam int VW  = $clog2(VOTES + 1);
  localparam int QTR = STEPS / 2;
  localparam logic [DW:0] MAXC = {1'b0, {DW{1'b1}}};
  localparam logic [MRW-1:0] LVL_BIT = MRW'(1) << 7;

  typedef enum logic [2:0] {IDLE, MRON, SETTLE, PULSE, SAMP, EVAL, MROFF, FIN} st_t;

  st_t           st;
  logic [DW-1:0] step;
  logic [7:0]    wcnt;
  logic [VW-1:0] vcnt;
  logic [LANES-1:0] vote, hit;

  wire          idle_or_fin = (st == IDLE) || (st == FIN);
  wire          busy  = !idle_or_fin;
  wire          go    = idle_or_fin && start;
  wire          last  = step == DW'(STEPS - 1);
  wire [DW:0]   sum   = {1'b0, step} + (DW+1)'(QTR);
  wire [DW-1:0] tgt   = (sum > MAXC) ? {DW{1'b1}} : sum[DW-1:0];

  assign mr_wr      = (st == MRON) || (st == MROFF);
  assign mr_reg     = 3'd1;
  assign mr_val     = (st == MRON) ? (mr1_base | LVL_BIT) : (mr1_base & ~LVL_BIT);
  assign strb_pulse = st == PULSE;
  assign done       = st == FIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; step <= '0; wcnt <= '0; vcnt <= '0;
    end else begin
      case (st)
        IDLE, FIN: if (start) begin st <= MRON; step <= '0; vcnt <= '0; end
        MRON:   begin wcnt <= settle_cycles; st <= SETTLE; end
        SETTLE: if (wcnt == 8'd0) st <= PULSE; else wcnt <= wcnt - 8'd1;
        PULSE:  st <= SAMP;
        SAMP: begin
          if (vcnt == VW'(VOTES - 1)) begin vcnt <= '0; st <= EVAL; end
          else begin vcnt <= vcnt + VW'(1); st <= PULSE; end
        end
        EVAL: begin
          if (last) st <= MROFF;
          else begin step <= step + DW'(1); wcnt <= settle_cycles; st <= SETTLE; end
        end
        MROFF:  st <= FIN;
        default: st <= IDLE;
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [VW-1:0] ones;
    logic          prev, found, fail;
    logic [DW-1:0] res;

    assign vote[l] = ones > VW'(VOTES / 2);
    assign hit[l]  = vote[l] && !prev && !found;
    assign dly[l*DW +: DW] = busy ? step : res;
    assign lane_fail[l] = fail;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ones <= '0; prev <= 1'b1; found <= 1'b0; fail <= 1'b0; res <= '0;
      end else if (go) begin
        ones <= '0; prev <= 1'b1; found <= 1'b0; fail <= 1'b0; res <= '0;
      end else if (st == SAMP) begin
        ones <= ones + VW'(lvl_fb[l]);
      end else if (st == EVAL) begin
        ones <= '0;
        prev <= vote[l];
        if (hit[l]) begin found <= 1'b1; res <= tgt; end
        if (last) fail <= !(found || hit[l]);
      end
    end
  end
endmodule

module wrlvl_ctrl_chk #(
  parameter int LANES = 8,
  parameter int STEPS = 64,
  parameter int MRW   = 13
)(
  input logic                           clk,
  input logic                           rst_n,
  input logic                           start,
  input logic [7:0]                     settle_cycles,
  input logic                           mr_wr,
  input logic [2:0]                     mr_reg,
  input logic [MRW-1:0]                 mr_val,
  input logic                           strb_pulse,
  input logic [LANES*$clog2(STEPS)-1:0] dly,
  input logic [LANES-1:0]               lane_fail,
  input logic                           done
);
  localparam int DW = $clog2(STEPS);

  logic [LANES*DW-1:0] dly_q;
  logic [8:0]          since;
  logic                fail_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0; since <= '0;
    end else begin
      dly_q <= dly;
      if (dly != dly_q) since <= '0;
      else if (since != 9'h1FF) since <= since + 9'd1;
    end
  end

  always_comb begin
    fail_nz = 1'b0;
    for (int l = 0; l < LANES; l++)
      if (lane_fail[l] && dly[l*DW +: DW] != '0) fail_nz = 1'b1;
  end

  // R1
  mr_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_wr && mr_val[7]) |-> ($past(start) && mr_reg == 3'd1));
  // R2
  mr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(mr_wr) && !$past(mr_val[7])));
  // R5
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fail_nz);
  // R7
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb_pulse |-> (since >= {1'b0, settle_cycles}));
  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mr_wr, strb_pulse}));
endmodule

bind wrlvl_ctrl wrlvl_ctrl_chk #(.LANES(LANES), .STEPS(STEPS), .MRW(MRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
  .mr_wr(mr_wr), .mr_reg(mr_reg), .mr_val(mr_val), .strb_pulse(strb_pulse),
  .dly(dly), .lane_fail(lane_fail), .done(done)
);

// File: tb/sim_wrlvl_ctrl.sv
module sim_wrlvl_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int STEPS = 64;
  localparam int VOTES = 3;
  localparam int MRW   = 13;
  localparam int DW    = $clog2(STEPS);
  localparam int MAXC  = (1 << DW) - 1;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] settle_cycles = 8'd3;
  logic [MRW-1:0] mr1_base = '0;
  logic mr_wr, strb_pulse, done;
  logic [2:0] mr_reg;
  logic [MRW-1:0] mr_val;
  logic [LANES-1:0] lvl_fb, lane_fail;
  logic [LANES*DW-1:0] dly;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrlvl_ctrl #(.LANES(LANES), .STEPS(STEPS), .VOTES(VOTES), .MRW(MRW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .mr1_base(mr1_base), .mr_wr(mr_wr), .mr_reg(mr_reg), .mr_val(mr_val),
    .strb_pulse(strb_pulse), .lvl_fb(lvl_fb), .dly(dly),
    .lane_fail(lane_fail), .done(done));

  int errs = 0, checks = 0, cyc = 0;
  int lo [LANES], hi [LANES], gs [LANES];
  int pcnt = 0, since = 0, settle_bad = 0, mr_seen = 0, pulses = 0;
  logic [DW-1:0] last0 = '0;
  logic [LANES*DW-1:0] lastd = '0;
  logic done_q = 0;
  int exp_q[$];
  string tag_q[$];

  // device model: per-lane feedback from the lane's own code, optional one-sample flip
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      int c;
      logic b;
      c = int'(dly[l*DW +: DW]);
      b = (c < lo[l]) ? 1'b1 : (c >= hi[l]);
      if (c == gs[l] && pcnt == 1) b = !b;
      lvl_fb[l] = b;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_lane(input int l, input int l_lo, input int l_hi, input int l_gs);
    lo[l] = l_lo; hi[l] = l_hi; gs[l] = l_gs;
  endtask

  task automatic run_case(input logic [7:0] s, input logic [MRW-1:0] base);
    for (int l = 0; l < LANES; l++) begin
      int prev, raw, code, fl;
      prev = 1; raw = -1;
      for (int c = 0; c < STEPS; c++) begin
        int b;
        b = (c < lo[l]) ? 1 : (c >= hi[l]) ? 1 : 0;
        if (raw < 0 && prev == 0 && b == 1) raw = c + STEPS/2;
        prev = b;
      end
      fl = (raw < 0);
      code = fl ? 0 : (raw > MAXC ? MAXC : raw);
      exp_q.push_back((fl << 16) | code);
      if (fl) tag_q.push_back("R5");
      else if (raw > MAXC) tag_q.push_back("R4");
      else if (gs[l] >= 0) tag_q.push_back("R6");
      else tag_q.push_back("R3");
    end
    settle_cycles = s; mr1_base = base;
    mr_seen = 0; pulses = 0; settle_bad = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(settle_bad == 0, "R7 settle", settle_bad, 0);
    chk(mr_seen == 2, "R2 mr write count", mr_seen, 2);
  endtask

  always @(negedge clk) begin
    if (dly != lastd) since = 0; else since++;
    lastd = dly;
    if (dly[DW-1:0] != last0) pcnt = 0;
    last0 = dly[DW-1:0];
    if (strb_pulse) begin
      pulses++;
      pcnt++;
      if (since < int'(settle_cycles)) settle_bad++;
    end
    if (mr_wr) begin
      mr_seen++;
      if (mr_seen == 1) begin
        chk(mr_val == (mr1_base | MRW'(128)) && mr_reg == 3'd1 && pulses == 0,
            "R1 leveling-on write", int'(mr_val), int'(mr1_base | MRW'(128)));
      end else begin
        chk(mr_val == (mr1_base & ~MRW'(128)) && mr_reg == 3'd1 && !done,
            "R2 leveling-off write", int'(mr_val), int'(mr1_base & ~MRW'(128)));
      end
    end
    if (done && !done_q) begin
      for (int l = 0; l < LANES; l++) begin
        int e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = (int'(lane_fail[l]) << 16) | int'(dly[l*DW +: DW]);
        chk(a == e, $sformatf("%s lane %0d", t, l), a, e);
      end
    end
    done_q = done;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < LANES; l++) set_lane(l, 0, STEPS, -1);
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(dly == '0, "R8 dly at reset", int'(dly[DW-1:0]), 0);
    chk(lane_fail == '0, "R8 fail at reset", int'(lane_fail), 0);
    chk(!done, "R8 done at reset", int'(done), 0);
    chk(!mr_wr && !strb_pulse, "R8 no commands at reset", int'({mr_wr, strb_pulse}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    set_lane(0, 0, 5, -1);    // 37
    set_lane(1, 0, 31, -1);   // 63 exact
    set_lane(2, 0, 32, -1);   // R4 saturates
    set_lane(3, 0, 50, -1);   // R4 saturates
    set_lane(4, 0, STEPS, -1);// R5 all zeros
    set_lane(5, STEPS, STEPS, -1); // R5 all ones
    set_lane(6, 5, 10, -1);   // high-low-high: 42
    set_lane(7, 0, 20, 10);   // R6 flip below edge: 52
    run_case(8'd3, 13'h0105);
    chk(done, "R2 done held", int'(done), 1);

    set_lane(0, 0, 1, -1);    // 33
    set_lane(1, 0, 63, -1);   // edge on last step, saturates
    set_lane(2, 3, 3, -1);    // R5 all ones
    set_lane(3, 0, 12, 12);   // R6 flip at edge: 44
    set_lane(4, 0, 7, -1);    // 39
    set_lane(5, 0, 2, -1);    // 34
    set_lane(6, 20, STEPS, -1); // R5 falls only
    set_lane(7, 0, 25, -1);   // 57
    run_case(8'd0, 13'h1FFF);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule